// File: doc/BRIEF.md
# Pseudo-Scanline Interrupt Counter

This block is an interrupt source for a cartridge-style expansion on a CPU write bus. Software programs an 8-bit reload value and then starts an 8-bit up-counter. The counter does not watch the video chip. Instead, a fractional prescaler turns CPU cycles into ticks that come at the rate of display lines. The prescaler adds 3 on each enabled CPU cycle and emits a tick each time its sum reaches 341, which gives a tick every 113 2/3 CPU cycles on average.

When the counter steps past its all-ones value, it reloads from the reload register and raises a level interrupt. The interrupt stays high until software writes one of the block's three registers. The acknowledge register also restores the counting enable from a flag that the control register saved earlier. This lets software choose, at start-up, whether the counter keeps running after each acknowledge or stops.

Three registers sit in the address page selected by the top address bits: reload, control and acknowledge. The low two address bits choose among them. A parameter swaps those two bits for boards where the two register lines are crossed.

Top module: `scanline_irq_gen`

## Requirements
- R1: Synchronous reset (active-high `rst`) clears the enable, the saved flag, the reload value, the counter, the prescaler and the interrupt. `irq_o` is low in the first cycle after reset.
- R2: A write with low bits 0 (address 0xF000 by default) stores `wr_data` as the reload value and clears a pending interrupt. It does not change the counter, the enable or the prescaler.
- R3: A write with low bits 1 (0xF001) sets the enable from data bit 1 and saves data bit 0 as the restore flag. If bit 1 is set, it also loads the counter from the reload value. With the enable clear, no counting takes place.
- R4: Every control write clears the prescaler to 0 and clears a pending interrupt.
- R5: A write with low bits 2 (0xF002) copies the saved flag into the enable and clears a pending interrupt.
- R6: On each cycle that is enabled and has `cpu_ce` high, the prescaler gains 3. When the sum is 341 or more, 341 is subtracted and the counter increments once.
- R7: An increment from 0xFF reloads the counter from the reload value and sets `irq_o`. `irq_o` then stays high until a register write clears it.
- R8: A write is decoded only when address bits 15:12 equal 0xF. Writes to other pages, and writes with low bits 3, change nothing.
- R9: With `SWAP_A01` set, address bits 0 and 1 are exchanged before decoding. For example, 0xF002 then selects control and 0xF001 selects acknowledge.
- R10: In a cycle that carries a decoded register write, the prescaler and counter do not advance.
- R11: While `cpu_ce` is low, the prescaler and counter hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One CPU cycle elapses in this clock |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The counter value and the prescaler phase cannot be seen at the ports. Only the instant at which `irq_o` rises shows them. The stimulus therefore uses reload values 0xFE and 0xFF, which make overflows come after one or two ticks. It holds the counter in place with back-to-back reload writes, and it restarts the prescaler with control writes spaced closer together than one tick. A reference model tracks the exact fractional phase, so a rise one cycle early or late shows up. A second instance with swapped address lines runs on the same bus, and the model compares it in every cycle as well.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
   typedef enum logic [1:0] {
      SEL_RELOAD = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_ACK    = 2'd2,
      SEL_NONE   = 2'd3
   } sirq_sel_e;

   localparam int CTRL_EN_BIT   = 1;
   localparam int CTRL_KEEP_BIT = 0;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
   import scanline_irq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int PAGE_W   = 4,
   parameter logic [PAGE_W-1:0] PAGE = '1,
   parameter bit SWAP_A01 = 1'b0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit_reload,
   output logic              hit_ctrl,
   output logic              hit_ack
);
   logic [1:0] low_bits;
   logic       page_ok;
   sirq_sel_e  sel;
   logic       unused_mid;

   generate
      if (SWAP_A01) begin : g_swap
         assign low_bits = {wr_addr[0], wr_addr[1]};
      end else begin : g_direct
         assign low_bits = wr_addr[1:0];
      end
   endgenerate

   assign unused_mid = ^wr_addr[ADDR_W-PAGE_W-1:2];
   assign page_ok    = wr_en && (wr_addr[ADDR_W-1 -: PAGE_W] == PAGE);

   always_comb begin
      sel = page_ok ? sirq_sel_e'(low_bits) : SEL_NONE;
   end

   assign hit_reload = (sel == SEL_RELOAD);
   assign hit_ctrl   = (sel == SEL_CTRL);
   assign hit_ack    = (sel == SEL_ACK);
endmodule

// File: rtl/sirq_prescaler.sv
module sirq_prescaler #(
   parameter int STEP   = 3,
   parameter int PERIOD = 341,
   parameter int W      = $clog2(PERIOD + STEP)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] pre_q,
   output logic         tick
);
   logic [W-1:0] sum;
   logic         wrap;

   assign sum  = pre_q + W'(STEP);
   assign wrap = (sum >= W'(PERIOD));
   assign tick = adv && wrap;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         pre_q <= '0;
      end else if (adv) begin
         pre_q <= wrap ? (sum - W'(PERIOD)) : sum;
      end
   end
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         tick,
   input  logic [W-1:0] reload_val,
   output logic         ovf
);
   logic [W-1:0] cnt_q;

   assign ovf = tick && (&cnt_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load || ovf) begin
         cnt_q <= reload_val;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
   import scanline_irq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 4,
   parameter logic [PAGE_W-1:0] PAGE = 4'hF,
   parameter bit SWAP_A01   = 1'b0,
   parameter int PRE_STEP   = 3,
   parameter int PRE_PERIOD = 341
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_ce,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              irq_o
);
   localparam int PRE_W = $clog2(PRE_PERIOD + PRE_STEP);

   generate
      if (PRE_STEP < 1 || PRE_STEP >= PRE_PERIOD) begin : g_bad_step
         $error("scanline_irq_gen: PRE_STEP must be in 1..PRE_PERIOD-1");
      end
      if (CNT_W <= CTRL_EN_BIT) begin : g_bad_width
         $error("scanline_irq_gen: CNT_W too small for control bits");
      end
      if (ADDR_W < PAGE_W + 2) begin : g_bad_addr
         $error("scanline_irq_gen: ADDR_W too small for page and select");
      end
   endgenerate

   logic             hit_reload, hit_ctrl, hit_ack, any_hit;
   logic             en_q, keep_q, adv, tick, ovf, ctr_load;
   logic [CNT_W-1:0] reload_q;
   logic [PRE_W-1:0] pre_q;

   sirq_decode #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE(PAGE), .SWAP_A01(SWAP_A01)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr),
      .hit_reload(hit_reload), .hit_ctrl(hit_ctrl), .hit_ack(hit_ack)
   );

   assign any_hit  = hit_reload || hit_ctrl || hit_ack;
   assign adv      = cpu_ce && en_q && !any_hit;
   assign ctr_load = hit_ctrl && wr_data[CTRL_EN_BIT];

   sirq_prescaler #(
      .STEP(PRE_STEP), .PERIOD(PRE_PERIOD), .W(PRE_W)
   ) u_pre (
      .clk(clk), .rst(rst), .clr(hit_ctrl), .adv(adv),
      .pre_q(pre_q), .tick(tick)
   );

   sirq_counter #(
      .W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst(rst), .load(ctr_load), .tick(tick),
      .reload_val(reload_q), .ovf(ovf)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         reload_q <= '0;
         en_q     <= 1'b0;
         keep_q   <= 1'b0;
         irq_o    <= 1'b0;
      end else begin
         if (hit_reload) reload_q <= wr_data;
         if (hit_ctrl) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            keep_q <= wr_data[CTRL_KEEP_BIT];
         end else if (hit_ack) begin
            en_q <= keep_q;
         end
         if (any_hit)  irq_o <= 1'b0;
         else if (ovf) irq_o <= 1'b1;
      end
   end
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
   parameter int PRE_PERIOD = 341,
   parameter int PRE_W      = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             cpu_ce,
   input logic             irq_o,
   input logic             hit_reload,
   input logic             hit_ctrl,
   input logic             hit_ack,
   input logic             en_q,
   input logic             tick,
   input logic [PRE_W-1:0] pre_q
);
   logic any_w;
   assign any_w = hit_reload || hit_ctrl || hit_ack;

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !irq_o);

   assert_reload_clears_R2: assert property (@(posedge clk) disable iff (rst)
      hit_reload |=> !irq_o);

   assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !any_w) |=> $stable(pre_q));

   assert_ctrl_clears_R4: assert property (@(posedge clk) disable iff (rst)
      hit_ctrl |=> (!irq_o && pre_q == '0));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
      hit_ack |=> !irq_o);

   assert_pre_range_R6: assert property (@(posedge clk) disable iff (rst)
      pre_q < PRE_W'(PRE_PERIOD));

   assert_irq_from_tick_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_o) |-> $past(tick));

   assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
      (irq_o && !any_w) |=> irq_o);

   assert_write_stalls_R10: assert property (@(posedge clk) disable iff (rst)
      (hit_reload || hit_ack) |=> $stable(pre_q));

   assert_ce_low_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!cpu_ce && !any_w) |=> $stable(pre_q));
endmodule

bind scanline_irq_gen sirq_checker #(
   .PRE_PERIOD(PRE_PERIOD), .PRE_W(PRE_W)
) u_sirq_chk (
   .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .irq_o(irq_o),
   .hit_reload(hit_reload), .hit_ctrl(hit_ctrl), .hit_ack(hit_ack),
   .en_q(en_q), .tick(tick), .pre_q(pre_q)
);

// File: tb/scanline_irq_gen_bench.sv
`timescale 1ns/1ps
module scanline_irq_gen_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_ce = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        irq_a, irq_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   string tag = "R1";

   always #2 clk = ~clk;

   scanline_irq_gen u_scanline_irq_gen (
      .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_a)
   );

   scanline_irq_gen #(.SWAP_A01(1'b1)) u_scanline_irq_gen_swap (
      .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_b)
   );

   // reference model: index 0 direct decode, index 1 swapped decode
   int m_reload[2], m_cnt[2], m_pre[2];
   bit m_en[2], m_keep[2], m_irq[2];

   function automatic int msel(bit swp);
      if (!wr_en || wr_addr[15:12] != 4'hF) return 3;
      if (swp) return {wr_addr[0], wr_addr[1]};
      return wr_addr[1:0];
   endfunction

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (rst) begin
            m_reload[k] = 0; m_cnt[k] = 0; m_pre[k] = 0;
            m_en[k] = 0; m_keep[k] = 0; m_irq[k] = 0;
         end else begin
            int s;
            s = msel(k == 1);
            if (s == 0) begin
               m_reload[k] = wr_data;
               m_irq[k] = 0;
            end else if (s == 1) begin
               m_en[k] = wr_data[1];
               m_keep[k] = wr_data[0];
               if (wr_data[1]) m_cnt[k] = m_reload[k];
               m_pre[k] = 0;
               m_irq[k] = 0;
            end else if (s == 2) begin
               m_en[k] = m_keep[k];
               m_irq[k] = 0;
            end else if (cpu_ce && m_en[k]) begin
               m_pre[k] += 3;
               if (m_pre[k] >= 341) begin
                  m_pre[k] -= 341;
                  if (m_cnt[k] == 255) begin
                     m_cnt[k] = m_reload[k];
                     m_irq[k] = 1;
                  end else m_cnt[k]++;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         n_cmp += 2;
         if (irq_a !== m_irq[0]) begin
            n_bad++;
            $display("FAIL %s direct irq actual=%b expected=%b t=%0t", tag, irq_a, m_irq[0], $time);
         end
         if (irq_b !== m_irq[1]) begin
            n_bad++;
            $display("FAIL %s swapped irq actual=%b expected=%b t=%0t", tag, irq_b, m_irq[1], $time);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s irq actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3);
      rst = 1'b0;
      cmp_on = 1'b1;
      idle(1);
      tag = "R1";
      chk(irq_a, 1'b0, "R1"); chk(irq_b, 1'b0, "R1");

      // R3 load from reload, R6 prescaler pacing, R7 overflow
      tag = "R6/R7";
      wr(16'hF000, 8'hFE);
      wr(16'hF001, 8'h02);
      idle(200); chk(irq_a, 1'b0, "R6");
      idle(40);  chk(irq_a, 1'b1, "R7");
      idle(300); chk(irq_a, 1'b1, "R7");

      // R5 acknowledge with keep flag clear stops counting
      tag = "R5";
      wr(16'hF002, 8'h00);
      chk(irq_a, 1'b0, "R5");
      idle(400); chk(irq_a, 1'b0, "R5");

      // keep flag set; R2 reload write clears pending irq
      tag = "R2";
      wr(16'hF000, 8'hFF);
      wr(16'hF001, 8'h03);
      idle(120); chk(irq_a, 1'b1, "R7");
      wr(16'hF000, 8'h10);
      chk(irq_a, 1'b0, "R2");
      idle(120); chk(irq_a, 1'b1, "R2");
      tag = "R5";
      wr(16'hF002, 8'h00);
      chk(irq_a, 1'b0, "R5");
      idle(300);

      // R3 disable, R4 clear
      tag = "R3/R4";
      wr(16'hF001, 8'h00);
      chk(irq_a, 1'b0, "R4");
      idle(500); chk(irq_a, 1'b0, "R3");

      // R8 ignored writes
      tag = "R8";
      wr(16'hF000, 8'hFF);
      wr(16'hE001, 8'h02);
      wr(16'h7001, 8'h02);
      wr(16'hF003, 8'h02);
      idle(300); chk(irq_a, 1'b0, "R8"); chk(irq_b, 1'b0, "R8");

      // R11 cpu_ce gating
      tag = "R11";
      cpu_ce = 1'b0;
      wr(16'hF001, 8'h02);
      idle(500); chk(irq_a, 1'b0, "R11");
      cpu_ce = 1'b1;
      idle(120); chk(irq_a, 1'b1, "R11");
      wr(16'hF001, 8'h02);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         cpu_ce = (i % 3) != 0;
      end
      cpu_ce = 1'b1;

      // R10 back-to-back writes stall counting
      tag = "R10";
      wr(16'hF001, 8'h02);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 16'hF000; wr_data = 8'hFF;
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(irq_a, 1'b0, "R10");
      idle(120); chk(irq_a, 1'b1, "R10");

      // R4 prescaler restart: control writes closer than one tick
      tag = "R4";
      for (int i = 0; i < 10; i++) begin
         wr(16'hF001, 8'h02);
         idle(98);
      end
      chk(irq_a, 1'b0, "R4");
      wr(16'hF001, 8'h00);

      // R9 swapped select lines
      tag = "R9";
      wr(16'hF000, 8'hFF);
      wr(16'hF002, 8'h02);
      idle(130);
      chk(irq_b, 1'b1, "R9"); chk(irq_a, 1'b0, "R9");
      wr(16'hF001, 8'h00);
      chk(irq_b, 1'b0, "R9");
      idle(4);

      finish_run();
   end
endmodule